// File: doc/BRIEF.md
# Two-Wire Slave Register Port

This block lets an external host on a two-wire serial bus read and write a 256-entry, byte-wide register file. The bus lines arrive unsynchronised. They pass through a two-flop synchroniser on the system clock, and the block then recognises START, STOP and repeated START. It compares the 7-bit chip address with a value captured from five strap pins. After a match it acts as a receiver or a transmitter, depending on the direction bit. The block pulls SDA low through an open-drain enable and never drives it high.

A pointer selects the register entry. The first byte written after a STOP (or after reset) loads the pointer, and each byte moved over the bus advances it by one. A STOP that follows a matched address returns the pointer to zero. A repeated START leaves it alone. A host can therefore set the pointer with a short write, turn the bus round with a repeated START and read from that entry. A later write can also carry on from the current entry without sending a new pointer byte.

On the register side there is a single synchronous port. It carries one address, a write strobe with data, and a read strobe whose data the register file returns on the next clock.

Top module: `twi_regslave`

## Requirements
- R1: The chip address is {2'b00, strap_i[4:0]}, so strap bit 4 is address bit 5 of the address byte. It is captured once when reset is released, and later strap changes have no effect on which address is acknowledged.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. The address byte is shifted in most significant bit first, and its bit 0 selects the direction: 1 = slave transmits (read), 0 = slave receives (write).
- R3: The slave acknowledges a matching address byte and every byte written to it by pulling SDA low during the ninth SCL clock. It changes its SDA drive only while SCL is low.
- R4: After a non-matching address byte, the slave acknowledges nothing and writes no register until a START is followed by a matching address.
- R5: In a write, the first data byte after the address loads the pointer and is not written to the register file, if no matched read or pointer byte has occurred since the last STOP or reset.
- R6: Every other written byte goes to the entry the pointer selects, and the pointer then advances by one, wrapping from 255 to 0.
- R7: In a read, the slave sends the entry at the pointer most significant bit first and advances the pointer once per byte sent. A master ACK makes it send the next entry. A master NACK makes it release SDA until the next START or STOP.
- R8: A STOP after a matched address sets the pointer to 0, so a read that directly follows a STOP returns entry 0 first.
- R9: A START or repeated START leaves the pointer unchanged. A read after a repeated START returns the current entry, and a write after a repeated START stores its first byte at the current entry with no pointer byte.
- R10: reg_wr_o is a one-cycle strobe, once per stored byte, with reg_addr_o and reg_wdata_o valid in that cycle. reg_rd_o is a one-cycle strobe, and reg_rdata_i is expected on the following clock. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, unsynchronised |
| sda_i | input | 1 | Bus data line as seen on the wire, unsynchronised |
| sda_drive_low_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| strap_i | input | 5 | Address strap pins |
| reg_addr_o | output | 8 | Register file entry (the pointer) |
| reg_wdata_o | output | 8 | Register file write data |
| reg_wr_o | output | 1 | Register file write strobe |
| reg_rd_o | output | 1 | Register file read strobe |
| reg_rdata_i | input | 8 | Register file read data, one clock after reg_rd_o |

## Verification
On every cycle the assertions check several things:
- the pointer clears after a STOP in a matched message and holds across a START;
- SDA drive changes only while the synchronised SCL is low;
- writes happen only inside a selected message;
- the read and write strobes are exclusive;
- the captured address stays fixed after reset.

The byte-level behaviour can only be shown by the bench's bus transactions:
- acknowledge placement;
- the choice between pointer byte and data byte;
- pointer wrap;
- data returned after STOP or after a repeated START;
- silence after a wrong address;
- release after a master NACK.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int TWI_DW = 8;
  localparam int TWI_AW = TWI_DW - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_RD_HOLD
  } twi_state_e;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o
);
  logic [LINES-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '1;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '1;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/twi_cond.sv
module twi_cond (
  input  logic clk,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_prev_q, sda_prev_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_i;
      sda_prev_q <= sda_i;
    end
  end

  assign start_o    = scl_i & scl_prev_q & sda_prev_q & ~sda_i;
  assign stop_o     = scl_i & scl_prev_q & ~sda_prev_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_prev_q;
  assign scl_fall_o = ~scl_i & scl_prev_q;
endmodule

// File: rtl/twi_engine.sv
module twi_engine
  import twi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic [TWI_AW-1:0] own_addr_i,
  output logic              sda_low_o,
  output logic [TWI_DW-1:0] reg_addr_o,
  output logic [TWI_DW-1:0] reg_wdata_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  input  logic [TWI_DW-1:0] reg_rdata_i
);
  localparam int BCW = $clog2(TWI_DW + 1);
  localparam logic [BCW-1:0] BYTE_END = BCW'(TWI_DW);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(TWI_DW - 1);

  twi_state_e        state_q, state_d;
  logic [BCW-1:0]    bitcnt_q, bitcnt_d;
  logic [TWI_DW-1:0] shreg_q, shreg_d;
  logic [TWI_DW-1:0] ptr_q, ptr_d;
  logic              rw_q, rw_d;
  logic              sel_q, sel_d;
  logic              need_sub_q, need_sub_d;
  logic              load_q, load_d;
  logic              wr_s, rd_s;

  always_comb begin
    state_d    = state_q;
    bitcnt_d   = bitcnt_q;
    shreg_d    = load_q ? reg_rdata_i : shreg_q;
    ptr_d      = ptr_q;
    rw_d       = rw_q;
    sel_d      = sel_q;
    need_sub_d = need_sub_q;
    load_d     = 1'b0;
    wr_s       = 1'b0;
    rd_s       = 1'b0;
    if (start_i) begin
      state_d  = ST_ADDR;
      bitcnt_d = '0;
    end else if (stop_i) begin
      state_d = ST_IDLE;
      sel_d   = 1'b0;
      if (sel_q) begin
        ptr_d      = '0;
        need_sub_d = 1'b1;
      end
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise_i) begin
            shreg_d  = {shreg_q[TWI_DW-2:0], sda_i};
            bitcnt_d = bitcnt_q + 1'b1;
          end else if (scl_fall_i && bitcnt_q == BYTE_END) begin
            if (state_q == ST_ADDR) begin
              if (shreg_q[TWI_DW-1:1] == own_addr_i) begin
                state_d = ST_ADDR_ACK;
                sel_d   = 1'b1;
                rw_d    = shreg_q[0];
                if (shreg_q[0]) begin
                  rd_s       = 1'b1;
                  load_d     = 1'b1;
                  need_sub_d = 1'b0;
                end
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              state_d = ST_WR_ACK;
              if (need_sub_q) begin
                ptr_d      = shreg_q;
                need_sub_d = 1'b0;
              end else begin
                wr_s  = 1'b1;
                ptr_d = ptr_q + 1'b1;
              end
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall_i) begin
          bitcnt_d = '0;
          state_d  = rw_q ? ST_RD : ST_WR;
        end
        ST_WR_ACK: if (scl_fall_i) begin
          bitcnt_d = '0;
          state_d  = ST_WR;
        end
        ST_RD: if (scl_fall_i) begin
          if (bitcnt_q == LAST_BIT) begin
            state_d = ST_RD_ACK;
            ptr_d   = ptr_q + 1'b1;
          end else begin
            shreg_d  = {shreg_q[TWI_DW-2:0], 1'b0};
            bitcnt_d = bitcnt_q + 1'b1;
          end
        end
        ST_RD_ACK: if (scl_rise_i) begin
          if (!sda_i) begin
            rd_s    = 1'b1;
            load_d  = 1'b1;
            state_d = ST_RD_HOLD;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_RD_HOLD: if (scl_fall_i) begin
          bitcnt_d = '0;
          state_d  = ST_RD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bitcnt_q   <= '0;
      shreg_q    <= '0;
      ptr_q      <= '0;
      rw_q       <= 1'b0;
      sel_q      <= 1'b0;
      need_sub_q <= 1'b1;
      load_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      bitcnt_q   <= bitcnt_d;
      shreg_q    <= shreg_d;
      ptr_q      <= ptr_d;
      rw_q       <= rw_d;
      sel_q      <= sel_d;
      need_sub_q <= need_sub_d;
      load_q     <= load_d;
    end
  end

  assign sda_low_o   = (state_q == ST_ADDR_ACK) || (state_q == ST_WR_ACK) ||
                       (state_q == ST_RD && !shreg_q[TWI_DW-1]);
  assign reg_addr_o  = ptr_q;
  assign reg_wdata_o = shreg_q;
  assign reg_wr_o    = wr_s;
  assign reg_rd_o    = rd_s;

  // R8: a STOP inside a selected message returns the pointer to entry 0
  p_stop_clears_ptr_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (stop_i && sel_q) |=> (ptr_q == '0));
  // R9: START leaves the pointer where it was
  p_start_keeps_ptr_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    start_i |=> $stable(ptr_q));
  // R3: drive changes only while synchronised SCL is low
  p_drive_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(sda_low_o) |-> !scl_i);
  // R4: no register write outside a selected message
  p_write_selected_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    reg_wr_o |-> sel_q);
  // R10: strobes never overlap
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    !(reg_wr_o && reg_rd_o));
endmodule

// File: rtl/twi_regslave.sv
module twi_regslave
  import twi_pkg::*;
#(
  parameter int STRAP_W    = 5,
  parameter int SYNC_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_drive_low_o,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [TWI_DW-1:0]  reg_addr_o,
  output logic [TWI_DW-1:0]  reg_wdata_o,
  output logic               reg_wr_o,
  output logic               reg_rd_o,
  input  logic [TWI_DW-1:0]  reg_rdata_i
);
  localparam int FIXED_W = TWI_AW - STRAP_W;

  logic              rst_meta_q, rst_n_s;
  logic              taken_q;
  logic [TWI_AW-1:0] own_q;
  logic [1:0]        lines_s;
  logic              start_s, stop_s, rise_s, fall_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      taken_q <= 1'b0;
      own_q   <= '0;
    end else if (!taken_q) begin
      taken_q <= 1'b1;
      own_q   <= {{FIXED_W{1'b0}}, strap_i};
    end
  end

  // R1: captured address never moves after the capture cycle
  p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    taken_q |=> $stable(own_q));

  twi_sync #(.LINES(2), .STAGES(SYNC_DEPTH)) u_sync (
    .clk    (clk),
    .rst_ni (rst_n_s),
    .d_i    ({scl_i, sda_i}),
    .q_o    (lines_s)
  );

  twi_cond u_cond (
    .clk        (clk),
    .rst_ni     (rst_n_s),
    .scl_i      (lines_s[1]),
    .sda_i      (lines_s[0]),
    .start_o    (start_s),
    .stop_o     (stop_s),
    .scl_rise_o (rise_s),
    .scl_fall_o (fall_s)
  );

  twi_engine u_engine (
    .clk         (clk),
    .rst_ni      (rst_n_s),
    .scl_i       (lines_s[1]),
    .sda_i       (lines_s[0]),
    .start_i     (start_s),
    .stop_i      (stop_s),
    .scl_rise_i  (rise_s),
    .scl_fall_i  (fall_s),
    .own_addr_i  (own_q),
    .sda_low_o   (sda_drive_low_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_wr_o    (reg_wr_o),
    .reg_rd_o    (reg_rd_o),
    .reg_rdata_i (reg_rdata_i)
  );
endmodule

// File: tb/twi_regslave_tb_top.sv
module twi_regslave_tb_top;
  localparam int Q = 10;
  localparam logic [7:0] DEV_W = 8'h34;
  localparam logic [7:0] DEV_R = 8'h35;
  localparam int NVEC = 6;
  // {pointer byte, data byte}
  localparam logic [15:0] VEC [NVEC] = '{16'h1033, 16'h2A5C, 16'h7FC3,
                                         16'h8001, 16'hC4FE, 16'hFE7E};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [4:0] strap = 5'b11010;
  logic sda_low, reg_wr, reg_rd;
  logic [7:0] reg_addr, reg_wdata, rdata;
  logic [7:0] regs [256];
  wire sda_bus = sda_m & ~sda_low;
  int checks = 0;
  int fails = 0;
  int wr_count = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  twi_regslave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_drive_low_o(sda_low), .strap_i(strap),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_wr_o(reg_wr), .reg_rd_o(reg_rd), .reg_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) regs[i] <= 8'(i * 7 + 3);
      rdata <= '0;
    end else begin
      if (reg_wr) begin
        regs[reg_addr] <= reg_wdata;
        wr_count <= wr_count + 1;
      end
      if (reg_rd) rdata <= regs[reg_addr];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw();
    scl_m = 1'b1; qw();
    sda_m = 1'b0; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw();
    scl_m = 1'b1; qw();
    sda_m = 1'b1; qw(); qw();
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw();
      scl_m = 1'b1; qw(); qw();
      scl_m = 1'b0; qw();
    end
    sda_m = 1'b1; qw();
    scl_m = 1'b1; qw();
    ack = (sda_bus == 1'b0);
    qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic recv(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; qw();
      scl_m = 1'b1; qw();
      b[i] = sda_bus;
      qw();
      scl_m = 1'b0; qw();
    end
    sda_m = ~mack; qw();
    scl_m = 1'b1; qw(); qw();
    scl_m = 1'b0; qw();
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b, b2;
    int wc;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    strap = 5'b00101;  // R1: later change must not move the address
    chk("R10 reset no drive", sda_low, 1'b0);
    chk("R10 reset no write strobe", reg_wr, 1'b0);
    chk("R10 reset no read strobe", reg_rd, 1'b0);

    // R8: read straight after reset returns entry 0 (initial value 3)
    bus_start(); send(DEV_R, ack); chk("R2 R3 read address ack", ack, 1'b1);
    recv(1'b0, b); chk("R8 first read entry 0", b, 8'h03); bus_stop();

    // table walk: pointer byte + data byte, then pointer write + Sr + read
    foreach (VEC[k]) begin
      wc = wr_count;
      bus_start(); send(DEV_W, ack); chk("R1 R3 strap address ack", ack, 1'b1);
      send(VEC[k][15:8], ack); chk("R3 pointer byte ack", ack, 1'b1);
      send(VEC[k][7:0], ack); chk("R3 data byte ack", ack, 1'b1);
      bus_stop();
      chk("R5 R10 one store per data byte", wr_count - wc, 1);
      bus_start(); send(DEV_W, ack); send(VEC[k][15:8], ack);
      bus_start(); send(DEV_R, ack); chk("R9 read after Sr ack", ack, 1'b1);
      recv(1'b0, b); chk("R6 R7 R9 readback", b, VEC[k][7:0]);
      chk("R7 release after NACK", sda_low, 1'b0);
      bus_stop();
    end

    // R6: wrap from 255 to 0, R7: multi-byte read with ACK then NACK
    bus_start(); send(DEV_W, ack); send(8'hFF, ack);
    send(8'hA1, ack); send(8'hB2, ack); bus_stop();
    bus_start(); send(DEV_W, ack); send(8'hFF, ack);
    bus_start(); send(DEV_R, ack);
    recv(1'b1, b); recv(1'b0, b2);
    chk("R6 R7 entry 255", b, 8'hA1);
    chk("R6 R7 wrapped entry 0", b2, 8'hB2);
    bus_stop();

    // R8: STOP after a matched write resets pointer; read returns entry 0
    bus_start(); send(DEV_W, ack); send(8'h50, ack); send(8'h9D, ack); bus_stop();
    bus_start(); send(DEV_R, ack); recv(1'b0, b);
    chk("R8 read after STOP gives entry 0", b, 8'hB2); bus_stop();

    // R4: wrong address, no ack, no store
    wc = wr_count;
    bus_start(); send(8'h36, ack); chk("R4 wrong address not acked", ack, 1'b0);
    send(8'h60, ack); chk("R4 byte after mismatch not acked", ack, 1'b0);
    send(8'h99, ack); chk("R4 second byte not acked", ack, 1'b0);
    bus_stop();
    chk("R4 no store after mismatch", wr_count - wc, 0);

    // R1: the strap value applied after reset is not the address
    bus_start(); send(8'h0A, ack); chk("R1 new strap value ignored", ack, 1'b0);
    bus_stop();

    // R9: write after Sr continues at current pointer with no pointer byte
    bus_start(); send(DEV_W, ack); send(8'h40, ack); send(8'h11, ack);
    bus_start(); send(DEV_W, ack); send(8'h22, ack);
    chk("R9 continued write acked", ack, 1'b1); bus_stop();
    bus_start(); send(DEV_W, ack); send(8'h40, ack);
    bus_start(); send(DEV_R, ack);
    recv(1'b1, b); recv(1'b0, b2);
    chk("R9 entry 0x40", b, 8'h11);
    chk("R9 entry 0x41 continued", b2, 8'h22);
    bus_stop();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule